// File: doc/BRIEF.md
# Vector Instruction Legality Checker

This block takes the operand description of one decoded vector instruction and decides whether it must raise an illegal-instruction exception. The inputs are the instruction's class, the configuration-invalid flag, the start index, the mask-enable bit, the destination and source register numbers, an element width, a segment field count and four signed log2 group multipliers, one each for the destination, source, index and data operands. A set of rule evaluators tests each legality condition on its own. A per-class selector then keeps only the rules that apply to the class. The selected rules are ORed into one illegal flag.

The per-rule flags come out next to the illegal flag, so the trap logic or a debug trace can see which condition fired. By default the result is registered, which adds one cycle of latency. A parameter can make the path purely combinational. Decoding the instruction bits and taking the trap are done elsewhere.

Top module: `vec_legal_check`

## Requirements
- R1: When `vill_i` is 1, every known class (codes 0 to 9) reports illegal and sets rule bit 0.
- R2: With `vm_i`=0 and `vd_i`=0, classes normal (0), variable-width (3), load (6) and indexed load (8) are illegal with rule bit 1. Store (7), indexed store (9), reduction (4), widening reduction (5) and unmasked (2) ignore this case.
- R3: The masked-only class (1) is illegal whenever `vd_i` is 0, whatever the value of `vm_i`, and sets rule bit 1.
- R4: The element width is legal only in the range 8 to ELEN, and the group multiplier log2 only in the range -3 to +3. Any violation sets rule bit 2. The check uses the destination multiplier for classes 3, 5, 6 and 7, and the index multiplier for classes 8 and 9.
- R5: In the variable-width class, when the source multiplier is smaller than the destination multiplier (widening), the instruction is legal only if the register groups are disjoint, or if both groups end at the same register and the source multiplier is at least 0. Otherwise rule bit 3 is set. The group size is 2^pow when pow is positive and 1 otherwise.
- R6: In the variable-width class, when the source multiplier is larger than the destination multiplier (narrowing), the instruction is legal only if the destination index is at or below the source index, or at or beyond the end of the source group. Otherwise rule bit 3 is set. Equal multipliers never violate this rule.
- R7: Segment limit. For a negative pow, floor(nf / 2^-pow) must not exceed 8. Otherwise nf * 2^pow must not exceed 8. A violation sets rule bit 5. The rule uses the destination multiplier for classes 6 and 7, and the data multiplier for classes 8 and 9.
- R8: Classes 4 and 5 are illegal with rule bit 4 whenever `vstart_i` is non-zero. No other class depends on `vstart_i`.
- R9: The unmasked class (2) depends only on `vill_i`. Class codes 10 to 15 are illegal with rule bit 6 alone.
- R10: `rules_o` bit k is set exactly when rule k applies to the class and is violated. `illegal_o` is the OR of all `rules_o` bits.
- R11: With REG_OUT=1 the outputs follow the inputs one clock later, and synchronous reset clears both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cls_i | input | 4 | Instruction class code |
| vill_i | input | 1 | Vector configuration invalid |
| vm_i | input | 1 | Mask enable, 0 means masked by v0 |
| vd_i | input | 5 | Destination register index |
| vs_i | input | 5 | Source register index |
| vstart_i | input | VSTART_W | Current start element index |
| eew_i | input | EEW_W | Element width under check, in bits |
| nf_i | input | 4 | Segment field count |
| dst_pow_i | input | 3 | Signed log2 group multiplier, destination |
| src_pow_i | input | 3 | Signed log2 group multiplier, source |
| idx_pow_i | input | 3 | Signed log2 group multiplier, index operand |
| data_pow_i | input | 3 | Signed log2 group multiplier, data operand |
| illegal_o | output | 1 | Instruction must trap |
| rules_o | output | 7 | Violated-rule flags, bits as in R1 to R9 |

## Verification
The hardest cases are the overlap boundaries. The rare legal widening case needs two groups that end on the same register, and the narrowing case needs a destination that lands exactly on the source base or on the register just past the source group. The bench reaches them by sweeping every pair of register indices from 0 to 15 against every combination of source and destination multipliers. That sweep includes the out-of-range value -4, which gives a group size of one. The indexed classes are driven with a destination multiplier that would fail the segment limit on its own, which shows that only the data and index multipliers are consulted.

// File: rtl/vlc_pkg.sv
package vlc_pkg;

    localparam int REG_W = 5;
    localparam int POW_W = 3;
    localparam int NF_W  = 4;
    localparam int SEG_MAX = 8;

    typedef enum logic [3:0] {
        CLS_NORMAL   = 4'd0,
        CLS_MASKED   = 4'd1,
        CLS_UNMASKED = 4'd2,
        CLS_VARWIDTH = 4'd3,
        CLS_RED      = 4'd4,
        CLS_REDW     = 4'd5,
        CLS_LOAD     = 4'd6,
        CLS_STORE    = 4'd7,
        CLS_ILOAD    = 4'd8,
        CLS_ISTORE   = 4'd9
    } vlc_class_e;

    // Raw condition results, before the class selects among them.
    typedef struct packed {
        logic vill;
        logic mask_v0;
        logic vd_zero;
        logic width_dst;
        logic width_idx;
        logic overlap;
        logic vstart;
        logic seg_dst;
        logic seg_data;
    } vlc_viol_t;

    // Reported rule flags; bit 0 is vill, bit 6 is the bad-class flag.
    typedef struct packed {
        logic cls_bad;
        logic seg;
        logic vstart;
        logic overlap;
        logic width;
        logic mask;
        logic vill;
    } vlc_rules_t;

    function automatic logic [6:0] grp_size(input logic signed [POW_W-1:0] p);
        return (p > 3'sd0) ? (7'd1 << p[1:0]) : 7'd1;
    endfunction

    function automatic logic emul_ok(input logic signed [POW_W-1:0] p);
        return (p >= -3'sd3);
    endfunction

    function automatic logic seg_ok(input logic [NF_W-1:0] nf,
                                    input logic signed [POW_W-1:0] p);
        logic [7:0] scaled;
        logic [2:0] mag;
        mag = 3'(-p);
        if (p < 3'sd0) scaled = {4'b0, nf} >> mag;
        else           scaled = {4'b0, nf} << p[1:0];
        return (scaled <= 8'(SEG_MAX));
    endfunction

    function automatic logic overlap_ok(input logic [REG_W-1:0] rs,
                                        input logic [REG_W-1:0] rd,
                                        input logic signed [POW_W-1:0] ps,
                                        input logic signed [POW_W-1:0] pd);
        logic [6:0] rsx, rdx, gs, gd;
        rsx = 7'(rs);
        rdx = 7'(rd);
        gs  = grp_size(ps);
        gd  = grp_size(pd);
        if (ps < pd)
            return (rsx + gs <= rdx) || (rsx >= rdx + gd) ||
                   ((rsx + gs == rdx + gd) && (ps >= 3'sd0));
        else if (ps > pd)
            return (rdx <= rsx) || (rdx >= rsx + gs);
        else
            return 1'b1;
    endfunction

endpackage

// File: rtl/vlc_rule_eval.sv
module vlc_rule_eval
    import vlc_pkg::*;
#(
    parameter int ELEN     = 64,
    parameter int EEW_W    = 8,
    parameter int VSTART_W = 8
) (
    input  logic                    vill_i,
    input  logic                    vm_i,
    input  logic [REG_W-1:0]        vd_i,
    input  logic [REG_W-1:0]        vs_i,
    input  logic [VSTART_W-1:0]     vstart_i,
    input  logic [EEW_W-1:0]        eew_i,
    input  logic [NF_W-1:0]         nf_i,
    input  logic signed [POW_W-1:0] dst_pow_i,
    input  logic signed [POW_W-1:0] src_pow_i,
    input  logic signed [POW_W-1:0] idx_pow_i,
    input  logic signed [POW_W-1:0] data_pow_i,
    output vlc_viol_t               viol_o
);
    localparam logic [EEW_W-1:0] EEW_MIN = EEW_W'(8);
    localparam logic [EEW_W-1:0] EEW_MAX = EEW_W'(ELEN);

    logic eew_in_range;

    always_comb begin
        eew_in_range       = (eew_i >= EEW_MIN) && (eew_i <= EEW_MAX);
        viol_o.vill        = vill_i;
        viol_o.vd_zero     = (vd_i == '0);
        viol_o.mask_v0     = !vm_i && (vd_i == '0);
        viol_o.width_dst   = !(eew_in_range && emul_ok(dst_pow_i));
        viol_o.width_idx   = !(eew_in_range && emul_ok(idx_pow_i));
        viol_o.overlap     = !overlap_ok(vs_i, vd_i, src_pow_i, dst_pow_i);
        viol_o.vstart      = (vstart_i != '0);
        viol_o.seg_dst     = !seg_ok(nf_i, dst_pow_i);
        viol_o.seg_data    = !seg_ok(nf_i, data_pow_i);
    end

endmodule

// File: rtl/vlc_class_sel.sv
module vlc_class_sel
    import vlc_pkg::*;
(
    input  logic [3:0] cls_i,
    input  vlc_viol_t  viol_i,
    output vlc_rules_t rules_o,
    output logic       illegal_o
);
    always_comb begin
        rules_o = '0;
        case (cls_i)
            CLS_NORMAL: begin
                rules_o.vill = viol_i.vill;
                rules_o.mask = viol_i.mask_v0;
            end
            CLS_MASKED: begin
                rules_o.vill = viol_i.vill;
                rules_o.mask = viol_i.vd_zero;
            end
            CLS_UNMASKED: begin
                rules_o.vill = viol_i.vill;
            end
            CLS_VARWIDTH: begin
                rules_o.vill    = viol_i.vill;
                rules_o.mask    = viol_i.mask_v0;
                rules_o.width   = viol_i.width_dst;
                rules_o.overlap = viol_i.overlap;
            end
            CLS_RED: begin
                rules_o.vill   = viol_i.vill;
                rules_o.vstart = viol_i.vstart;
            end
            CLS_REDW: begin
                rules_o.vill   = viol_i.vill;
                rules_o.vstart = viol_i.vstart;
                rules_o.width  = viol_i.width_dst;
            end
            CLS_LOAD: begin
                rules_o.vill  = viol_i.vill;
                rules_o.mask  = viol_i.mask_v0;
                rules_o.width = viol_i.width_dst;
                rules_o.seg   = viol_i.seg_dst;
            end
            CLS_STORE: begin
                rules_o.vill  = viol_i.vill;
                rules_o.width = viol_i.width_dst;
                rules_o.seg   = viol_i.seg_dst;
            end
            CLS_ILOAD: begin
                rules_o.vill  = viol_i.vill;
                rules_o.mask  = viol_i.mask_v0;
                rules_o.width = viol_i.width_idx;
                rules_o.seg   = viol_i.seg_data;
            end
            CLS_ISTORE: begin
                rules_o.vill  = viol_i.vill;
                rules_o.width = viol_i.width_idx;
                rules_o.seg   = viol_i.seg_data;
            end
            default: rules_o.cls_bad = 1'b1;
        endcase
        illegal_o = |rules_o;
    end

endmodule

// File: rtl/vec_legal_check.sv
module vec_legal_check
    import vlc_pkg::*;
#(
    parameter int ELEN     = 64,
    parameter int EEW_W    = 8,
    parameter int VSTART_W = 8,
    parameter bit REG_OUT  = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [3:0]              cls_i,
    input  logic                    vill_i,
    input  logic                    vm_i,
    input  logic [REG_W-1:0]        vd_i,
    input  logic [REG_W-1:0]        vs_i,
    input  logic [VSTART_W-1:0]     vstart_i,
    input  logic [EEW_W-1:0]        eew_i,
    input  logic [NF_W-1:0]         nf_i,
    input  logic signed [POW_W-1:0] dst_pow_i,
    input  logic signed [POW_W-1:0] src_pow_i,
    input  logic signed [POW_W-1:0] idx_pow_i,
    input  logic signed [POW_W-1:0] data_pow_i,
    output logic                    illegal_o,
    output logic [6:0]              rules_o
);
    vlc_viol_t  viol;
    vlc_rules_t comb_rules;
    logic       comb_illegal;

    vlc_rule_eval #(
        .ELEN     (ELEN),
        .EEW_W    (EEW_W),
        .VSTART_W (VSTART_W)
    ) u_eval (
        .vill_i     (vill_i),
        .vm_i       (vm_i),
        .vd_i       (vd_i),
        .vs_i       (vs_i),
        .vstart_i   (vstart_i),
        .eew_i      (eew_i),
        .nf_i       (nf_i),
        .dst_pow_i  (dst_pow_i),
        .src_pow_i  (src_pow_i),
        .idx_pow_i  (idx_pow_i),
        .data_pow_i (data_pow_i),
        .viol_o     (viol)
    );

    vlc_class_sel u_sel (
        .cls_i     (cls_i),
        .viol_i    (viol),
        .rules_o   (comb_rules),
        .illegal_o (comb_illegal)
    );

    // Configuration invalid traps every known class.
    p_vill_traps_r1: assert property (@(posedge clk) disable iff (rst)
        (vill_i && cls_i <= 4'd9) |-> comb_illegal);

    // Masked-only class never accepts v0 as destination.
    p_masked_vd0_r3: assert property (@(posedge clk) disable iff (rst)
        (cls_i == 4'(CLS_MASKED) && vd_i == '0) |-> comb_illegal);

    // Reductions with a non-zero start index trap.
    p_red_vstart_r8: assert property (@(posedge clk) disable iff (rst)
        ((cls_i == 4'(CLS_RED) || cls_i == 4'(CLS_REDW)) && vstart_i != '0)
            |-> comb_illegal);

    // Unmasked class result tracks only the configuration flag.
    p_unmasked_vill_r9: assert property (@(posedge clk) disable iff (rst)
        (cls_i == 4'(CLS_UNMASKED)) |-> (comb_illegal == vill_i));

    // Equal multipliers never produce an overlap violation.
    p_equal_pow_r6: assert property (@(posedge clk) disable iff (rst)
        (cls_i == 4'(CLS_VARWIDTH) && src_pow_i == dst_pow_i) |-> !comb_rules.overlap);

    generate
        if (REG_OUT) begin : g_reg
            logic       ill_q;
            vlc_rules_t rules_q;
            logic       armed;

            always_ff @(posedge clk) begin
                if (rst) begin
                    ill_q   <= 1'b0;
                    rules_q <= '0;
                    armed   <= 1'b0;
                end else begin
                    ill_q   <= comb_illegal;
                    rules_q <= comb_rules;
                    armed   <= 1'b1;
                end
            end

            assign illegal_o = ill_q;
            assign rules_o   = rules_q;

            p_reg_latency_r11: assert property (@(posedge clk) disable iff (rst)
                armed |-> (illegal_o == $past(comb_illegal)));
        end else begin : g_comb
            assign illegal_o = comb_illegal;
            assign rules_o   = comb_rules;
        end
    endgenerate

endmodule

// File: tb/tb_vec_legal_check.sv
module tb_vec_legal_check;
    localparam int CLK_PERIOD = 10;
    localparam int ELEN_T     = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [3:0]        cls_i = '0;
    logic              vill_i = 1'b0;
    logic              vm_i = 1'b1;
    logic [4:0]        vd_i = '0;
    logic [4:0]        vs_i = '0;
    logic [7:0]        vstart_i = '0;
    logic [7:0]        eew_i = 8'd32;
    logic [3:0]        nf_i = 4'd1;
    logic signed [2:0] dst_pow_i = '0;
    logic signed [2:0] src_pow_i = '0;
    logic signed [2:0] idx_pow_i = '0;
    logic signed [2:0] data_pow_i = '0;
    logic              illegal_o;
    logic [6:0]        rules_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_legal_check dut (
        .clk(clk), .rst(rst), .cls_i(cls_i), .vill_i(vill_i), .vm_i(vm_i),
        .vd_i(vd_i), .vs_i(vs_i), .vstart_i(vstart_i), .eew_i(eew_i), .nf_i(nf_i),
        .dst_pow_i(dst_pow_i), .src_pow_i(src_pow_i), .idx_pow_i(idx_pow_i),
        .data_pow_i(data_pow_i), .illegal_o(illegal_o), .rules_o(rules_o)
    );

    function automatic int grp(int p);
        return (p > 0) ? (1 << p) : 1;
    endfunction

    function automatic bit width_bad(int eew, int p);
        return !(eew >= 8 && eew <= ELEN_T && p >= -3 && p <= 3);
    endfunction

    function automatic bit seg_bad(int nf, int p);
        if (p < 0) return (nf / (1 << (-p))) > 8;
        return (nf * (1 << p)) > 8;
    endfunction

    function automatic bit ovl_bad(int rs, int rd, int ps, int pd);
        int gs = grp(ps);
        int gd = grp(pd);
        if (ps < pd)
            return !((rs + gs <= rd) || (rs >= rd + gd) || ((rs + gs == rd + gd) && ps >= 0));
        if (ps > pd)
            return !((rd <= rs) || (rd >= rs + gs));
        return 0;
    endfunction

    // Expected rule vector: bit0 vill, 1 mask, 2 width, 3 overlap, 4 vstart, 5 seg, 6 class.
    function automatic logic [6:0] model();
        logic [6:0] r = '0;
        int c   = int'(cls_i);
        bit m0  = (vm_i == 1'b0) && (vd_i == 0);
        int pd  = int'(dst_pow_i);
        int ps  = int'(src_pow_i);
        int pi  = int'(idx_pow_i);
        int pdt = int'(data_pow_i);
        int e   = int'(eew_i);
        int nf  = int'(nf_i);
        if (c > 9) begin
            r[6] = 1'b1;
            return r;
        end
        r[0] = vill_i;
        case (c)
            0: r[1] = m0;
            1: r[1] = (vd_i == 0);
            3: begin r[1] = m0; r[2] = width_bad(e, pd); r[3] = ovl_bad(vs_i, vd_i, ps, pd); end
            4: r[4] = (vstart_i != 0);
            5: begin r[4] = (vstart_i != 0); r[2] = width_bad(e, pd); end
            6: begin r[1] = m0; r[2] = width_bad(e, pd); r[5] = seg_bad(nf, pd); end
            7: begin r[2] = width_bad(e, pd); r[5] = seg_bad(nf, pd); end
            8: begin r[1] = m0; r[2] = width_bad(e, pi); r[5] = seg_bad(nf, pdt); end
            9: begin r[2] = width_bad(e, pi); r[5] = seg_bad(nf, pdt); end
            default: ;
        endcase
        return r;
    endfunction

    task automatic check(input string req, input logic got_i, input logic [6:0] got_r,
                         input logic exp_i, input logic [6:0] exp_r);
        n_checks++;
        if (got_i !== exp_i || got_r !== exp_r) begin
            n_errors++;
            $display("FAIL %s: cls=%0d vd=%0d vs=%0d pd=%0d ps=%0d got illegal=%b rules=%b expected illegal=%b rules=%b",
                     req, cls_i, vd_i, vs_i, dst_pow_i, src_pow_i, got_i, got_r, exp_i, exp_r);
        end
    endtask

    // Inputs are already stable; one edge for the output register, sample at the falling edge.
    task automatic step_check(input string req);
        logic [6:0] e;
        e = model();
        @(posedge clk);
        @(negedge clk);
        check(req, illegal_o, rules_o, |e, e);
    endtask

    task automatic defaults();
        vill_i = 0; vm_i = 1; vd_i = 5'd8; vs_i = 5'd16; vstart_i = 0;
        eew_i = 8'd32; nf_i = 4'd1; dst_pow_i = 0; src_pow_i = 0;
        idx_pow_i = 0; data_pow_i = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // R11: reset clears outputs even with a trapping input present.
        defaults();
        vill_i = 1; cls_i = 4'd15;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 reset", illegal_o, rules_o, 1'b0, 7'b0);
        rst = 0;
        defaults(); cls_i = 4'd0;
        step_check("R11 legal after reset");
        // R11: one-cycle latency - output holds before the edge.
        vill_i = 1;
        #1;
        check("R11 latency hold", illegal_o, rules_o, 1'b0, 7'b0);
        step_check("R11 latency update");

        // R1 R2 R3 R8 R9 R10: all class codes against vill, vm, vd and vstart.
        for (int c = 0; c < 16; c++)
            for (int v = 0; v < 2; v++)
                for (int m = 0; m < 2; m++)
                    for (int d = 0; d < 3; d++)
                        for (int s = 0; s < 3; s++) begin
                            defaults();
                            cls_i = 4'(c); vill_i = v[0]; vm_i = m[0];
                            vd_i = (d == 0) ? 5'd0 : (d == 1) ? 5'd1 : 5'd5;
                            vstart_i = (s == 0) ? 8'd0 : (s == 1) ? 8'd1 : 8'd255;
                            step_check("R1/R2/R3/R8/R9/R10 class sweep");
                        end

        // R5 R6: overlap sweep in the variable-width class.
        for (int rd = 0; rd < 16; rd++)
            for (int rs = 0; rs < 16; rs++)
                for (int ps = -4; ps <= 3; ps++)
                    for (int pd = -3; pd <= 3; pd++) begin
                        defaults();
                        cls_i = 4'd3; eew_i = 8'd16;
                        vd_i = 5'(rd); vs_i = 5'(rs);
                        src_pow_i = 3'(ps); dst_pow_i = 3'(pd);
                        step_check((ps < pd) ? "R5 widening overlap" : "R6 narrowing overlap");
                    end

        // R4: width and multiplier ranges, destination vs index operand.
        for (int e = 0; e < 256; e++)
            for (int p = -4; p <= 3; p++) begin
                defaults(); cls_i = 4'd6; eew_i = 8'(e); dst_pow_i = 3'(p);
                step_check("R4 load width");
                defaults(); cls_i = 4'd8; eew_i = 8'(e); idx_pow_i = 3'(p);
                dst_pow_i = -3'sd4;
                step_check("R4 indexed width");
            end

        // R7: segment limit, destination multiplier vs data multiplier.
        for (int n = 0; n < 16; n++)
            for (int p = -4; p <= 3; p++) begin
                defaults(); cls_i = 4'd7; nf_i = 4'(n); dst_pow_i = 3'(p); eew_i = 8'd8;
                step_check("R7 store segment");
                for (int q = -3; q <= 3; q++) begin
                    defaults(); cls_i = 4'd9; nf_i = 4'(n); data_pow_i = 3'(p);
                    idx_pow_i = 3'(q); dst_pow_i = 3'sd3;
                    step_check("R7 indexed segment");
                end
            end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule